// File: doc/BRIEF.md
# Open-Drain Trigger Line Transceiver

This block shares one active-low, wired-AND trigger line with other devices. It never drives the line high. It only switches a pad pull-down on and off, and an external resistor pulls the line back to its idle high level. Every timed decision advances on a slow timing tick (nominally 32 kHz), given as a one-cycle enable on the fast system clock. Internal sequencing logic asks for an outgoing trigger with a one-cycle `send_req`. The block then holds the line low for a fixed number of ticks.

The raw pad level passes through a synchronizer and is sampled on each tick. A low counts as a trigger only after it has been seen on a minimum number of consecutive ticks. Each qualified low yields a single one-cycle `trig_rcvd` pulse. The receiver is blanked while the block's own pulse is pending or on the wire, and for a guard interval after release, so it never hears itself.

Transmit states: TX_IDLE goes to TX_ARM on a request. TX_ARM goes to TX_DRIVE on the next tick. TX_DRIVE goes to TX_GUARD on its last tick. TX_GUARD goes to TX_IDLE when the guard ticks run out, or back to TX_ARM on a new request. Receive states: RX_IDLE goes to RX_LOW on a low sample while not blanked. RX_LOW goes to RX_HELD on the qualifying sample, which also fires the pulse. RX_LOW goes back to RX_IDLE on a high sample or on blanking. RX_HELD goes back to RX_IDLE on a high sample.

Top module: `trig_line_xcvr`

## Requirements
- R1: After reset `pad_oe`, `busy` and `trig_rcvd` are 0, and the synchronized line is taken as idle high.
- R2: A `send_req` while idle raises `busy` in the next cycle, and `pad_oe` rises right after the next tick edge, no more than one tick period later.
- R3: `pad_oe` stays high for exactly TX_TICKS (default 3) tick periods and then falls. The block has no output that drives the line high.
- R4: `busy` is high whenever `pad_oe` is high and falls in the same cycle that `pad_oe` falls.
- R5: A `send_req` while `busy` is high is ignored: the pulse length is unchanged and no second pulse follows.
- R6: A line low that covers fewer than RX_MIN (default 2) consecutive tick samples produces no `trig_rcvd`.
- R7: A line low that covers at least RX_MIN consecutive tick samples produces a `trig_rcvd` pulse exactly one clock cycle wide.
- R8: A single low event, however long, produces only one pulse. A new pulse needs the line to be sampled high first.
- R9: The block's own outgoing pulse never produces `trig_rcvd`. The receiver is blanked from request through one tick after release.
- R10: An external low that overlaps the block's own send is discarded while blanked. If it persists for RX_MIN samples after the blanking ends, it qualifies as a new trigger.
- R11: Asserting reset in the middle of a pulse releases the line (`pad_oe` is 0) at once and clears `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing tick enable (32 kHz rate) |
| send_req | input | 1 | One-cycle request to send a trigger |
| pad_in | input | 1 | Raw pad level of the shared line |
| pad_oe | output | 1 | Enable for the pad pull-down (1 = pull line low) |
| busy | output | 1 | Outgoing trigger pending or being driven |
| trig_rcvd | output | 1 | One-cycle pulse per qualified incoming trigger |

## Verification
Reception qualification and an own send can meet on the same tick edge. An external low that has been sampled once is still in RX_LOW when a request arrives. The next tick would both qualify that low and move the transmitter into TX_DRIVE. The bench provokes this by aligning to the tick, pulling the line low externally, and issuing `send_req` between the first and second low samples. It judges the result in two ways. If the external low ends during the drive, no `trig_rcvd` may appear and the outgoing pulse keeps its full length. If the external low outlasts the guard, exactly one `trig_rcvd` must follow.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARM   = 2'd1,
        TX_DRIVE = 2'd2,
        TX_GUARD = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_LOW  = 2'd1,
        RX_HELD = 2'd2
    } rx_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/trig_tx.sv
module trig_tx
    import trig_pkg::*;
#(
    parameter int TX_TICKS    = 3,
    parameter int GUARD_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic send_req,
    output logic pad_oe,
    output logic busy,
    output logic blank
);
    localparam int CW = $clog2(max2(TX_TICKS, GUARD_TICKS) + 1);
    localparam logic [CW-1:0] DRV_LAST = CW'(TX_TICKS - 1);
    localparam logic [CW-1:0] GRD_LAST = CW'(GUARD_TICKS - 1);

    tx_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            TX_IDLE: begin
                if (send_req) state_n = TX_ARM;
            end
            TX_ARM: begin
                if (tick) begin
                    state_n = TX_DRIVE;
                    cnt_n   = '0;
                end
            end
            TX_DRIVE: begin
                if (tick) begin
                    if (cnt == DRV_LAST) begin
                        state_n = TX_GUARD;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            TX_GUARD: begin
                if (send_req) begin
                    state_n = TX_ARM;
                end else if (tick) begin
                    if (cnt == GRD_LAST) state_n = TX_IDLE;
                    else                 cnt_n   = cnt + 1'b1;
                end
            end
            default: state_n = TX_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_oe <= 1'b0;
            busy   <= 1'b0;
        end else begin
            pad_oe <= (state_n == TX_DRIVE);
            busy   <= (state_n == TX_ARM) || (state_n == TX_DRIVE);
        end
    end

    assign blank = (state != TX_IDLE);

    // checker: ticks seen while the pull-down is on
    logic [CW:0] drv_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         drv_seen <= '0;
        else if (!pad_oe)   drv_seen <= '0;
        else if (tick)      drv_seen <= drv_seen + 1'b1;
    end

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe) |-> (drv_seen == (CW+1)'(TX_TICKS))); // R3
    AST_REQ_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && !busy) |=> busy); // R2
    AST_BUSY_ENDS_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(pad_oe)); // R4
    AST_OE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> busy); // R4

endmodule

// File: rtl/trig_rx.sv
module trig_rx
    import trig_pkg::*;
#(
    parameter int RX_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_hi,
    input  logic blank,
    output logic trig_rcvd
);
    localparam int CW = $clog2(RX_MIN + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(RX_MIN - 1);

    rx_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        fire    = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (tick && !blank && !line_hi) begin
                    state_n = RX_LOW;
                    cnt_n   = CW'(1);
                end
            end
            RX_LOW: begin
                if (tick) begin
                    if (blank || line_hi) begin
                        state_n = RX_IDLE;
                        cnt_n   = '0;
                    end else if (cnt == QUAL_LAST) begin
                        state_n = RX_HELD;
                        cnt_n   = '0;
                        fire    = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            RX_HELD: begin
                if (tick && line_hi) state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_rcvd <= 1'b0;
        else        trig_rcvd <= fire;
    end

    // checker: run of consecutive low tick samples, saturating
    logic [CW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run <= '0;
        else if (tick) begin
            if (line_hi)                   low_run <= '0;
            else if (low_run != CW'(RX_MIN)) low_run <= low_run + 1'b1;
        end
    end

    AST_RCVD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rcvd |=> !trig_rcvd); // R7
    AST_RCVD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rcvd |-> (low_run == CW'(RX_MIN))); // R6

endmodule

// File: rtl/trig_line_xcvr.sv
module trig_line_xcvr #(
    parameter int TX_TICKS    = 3,
    parameter int RX_MIN      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic send_req,
    input  logic pad_in,
    output logic pad_oe,
    output logic busy,
    output logic trig_rcvd
);
    logic line_hi;
    logic blank;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (line_hi)
    );

    trig_tx #(.TX_TICKS(TX_TICKS), .GUARD_TICKS(GUARD_TICKS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .send_req (send_req),
        .pad_oe   (pad_oe),
        .busy     (busy),
        .blank    (blank)
    );

    trig_rx #(.RX_MIN(RX_MIN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .line_hi   (line_hi),
        .blank     (blank),
        .trig_rcvd (trig_rcvd)
    );

    AST_NO_SELF_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rcvd |-> !$past(pad_oe)); // R9
    AST_NO_RCVD_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rcvd |-> !$past(busy)); // R10

endmodule

// File: tb/sim_trig_line_xcvr.sv
`timescale 1ns/1ps
module sim_trig_line_xcvr;
    localparam int TP = 8;      // clock cycles per tick
    localparam int TXT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic send_req = 1'b0;
    logic ext_low = 1'b0;
    logic pad_in, pad_oe, busy, trig_rcvd;

    int checks = 0;
    int failures = 0;
    int rcvd_total = 0;
    int rcvd_width = 0;
    int rcvd_maxw = 0;
    int oe_rises = 0;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign pad_in = ~(pad_oe | ext_low);

    trig_line_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .send_req(send_req),
        .pad_in(pad_in), .pad_oe(pad_oe), .busy(busy), .trig_rcvd(trig_rcvd)
    );

    // tick generator, driven away from both edges
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            #2;
            ph = (ph == TP-1) ? 0 : ph + 1;
            tick = (ph == TP-1);
        end
    end

    // output monitors
    always @(negedge clk) begin
        if (trig_rcvd) begin
            rcvd_width = rcvd_width + 1;
            if (rcvd_width == 1) rcvd_total = rcvd_total + 1;
            if (rcvd_width > rcvd_maxw) rcvd_maxw = rcvd_width;
        end else begin
            rcvd_width = 0;
        end
        if (pad_oe && !oe_prev) oe_rises = oe_rises + 1;
        oe_prev = pad_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req();
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
    endtask

    task automatic align_tick();
        do @(negedge clk); while (!tick);
        @(negedge clk);   // just after the tick edge
    endtask

    // waits for the pull-down, returns its length; checks busy throughout
    task automatic measure_oe(output int len, output int busy_bad, output int busy_after);
        len = 0; busy_bad = 0;
        while (!pad_oe) @(negedge clk);
        while (pad_oe) begin
            len++;
            if (!busy) busy_bad++;
            @(negedge clk);
        end
        busy_after = busy;
    endtask

    task automatic t_reset();
        check(pad_oe == 0, "R1 pad_oe", pad_oe, 0);
        check(busy == 0, "R1 busy", busy, 0);
        check(trig_rcvd == 0, "R1 trig_rcvd", trig_rcvd, 0);
    endtask

    task automatic t_send_basic();
        int len, bb, ba, wait_c, r0;
        r0 = rcvd_total;
        pulse_req();
        check(busy == 1, "R2 busy after request", busy, 1);
        wait_c = 0;
        while (!pad_oe) begin wait_c++; @(negedge clk); end
        check(wait_c <= TP, "R2 oe start within one tick", wait_c, TP);
        measure_oe(len, bb, ba);
        check(len == TXT*TP, "R3 pulse length", len, TXT*TP);
        check(bb == 0, "R4 busy low during drive", bb, 0);
        check(ba == 0, "R4 busy drops with oe", ba, 0);
        cyc(4*TP);
        check(rcvd_total == r0, "R9 no self trigger", rcvd_total - r0, 0);
    endtask

    task automatic t_send_ignored();
        int len, bb, ba, o0;
        o0 = oe_rises;
        pulse_req();
        while (!pad_oe) @(negedge clk);
        cyc(TP);
        pulse_req();
        len = TP + 1;
        while (pad_oe) begin len++; @(negedge clk); end
        check(len == TXT*TP, "R5 length unchanged", len, TXT*TP);
        cyc(4*TP);
        check(oe_rises - o0 == 1, "R5 no second pulse", oe_rises - o0, 1);
        check(pad_oe == 0 && busy == 0, "R5 idle after", busy, 0);
        bb = 0; ba = 0; len = 0;
    endtask

    task automatic t_short_low();
        int r0;
        r0 = rcvd_total;
        ext_low = 1'b1; cyc(TP); ext_low = 1'b0;
        cyc(3*TP);
        check(rcvd_total == r0, "R6 short low ignored", rcvd_total - r0, 0);
    endtask

    task automatic t_exact_low();
        int r0;
        r0 = rcvd_total; rcvd_maxw = 0;
        ext_low = 1'b1; cyc(2*TP); ext_low = 1'b0;
        cyc(3*TP);
        check(rcvd_total - r0 == 1, "R7 two-tick low qualifies", rcvd_total - r0, 1);
        check(rcvd_maxw == 1, "R7 pulse width", rcvd_maxw, 1);
    endtask

    task automatic t_long_low();
        int r0;
        r0 = rcvd_total;
        ext_low = 1'b1; cyc(10*TP); ext_low = 1'b0;
        cyc(2*TP);
        check(rcvd_total - r0 == 1, "R8 one pulse per long low", rcvd_total - r0, 1);
        ext_low = 1'b1; cyc(3*TP); ext_low = 1'b0;
        cyc(3*TP);
        check(rcvd_total - r0 == 2, "R8 new event after high", rcvd_total - r0, 2);
    endtask

    task automatic t_collide(input bit persist);
        int r0, len, bb, ba;
        r0 = rcvd_total;
        align_tick();
        ext_low = 1'b1;
        cyc(TP);          // one low sample taken
        cyc(2);
        pulse_req();      // lands before the qualifying tick
        while (!pad_oe) @(negedge clk);
        if (!persist) begin
            cyc(TP); ext_low = 1'b0;
            len = TP;
            while (pad_oe) begin len++; @(negedge clk); end
            check(len == TXT*TP, "R3 pulse length under collision", len, TXT*TP);
            cyc(4*TP);
            check(rcvd_total == r0, "R10 overlapped low discarded", rcvd_total - r0, 0);
        end else begin
            measure_oe(len, bb, ba);
            cyc(5*TP); ext_low = 1'b0;
            cyc(3*TP);
            check(rcvd_total - r0 == 1, "R10 persisting low qualifies", rcvd_total - r0, 1);
        end
    endtask

    task automatic t_reset_mid();
        pulse_req();
        while (!pad_oe) @(negedge clk);
        cyc(TP);
        rst_n = 1'b0;
        #1;
        check(pad_oe == 0, "R11 line released on reset", pad_oe, 0);
        check(busy == 0, "R11 busy cleared on reset", busy, 0);
        cyc(2);
        rst_n = 1'b1;
        cyc(2*TP);
        check(pad_oe == 0 && trig_rcvd == 0, "R11 idle after reset", pad_oe, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2*TP);
        t_reset();
        t_send_basic();
        t_send_ignored();
        t_short_low();
        t_exact_low();
        t_long_low();
        t_collide(1'b0);
        t_collide(1'b1);
        t_reset_mid();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule